// File: doc/BRIEF.md
# Shared-Port Switch Claim Controller

This block arbitrates ownership of the second port of a dual-port high-speed USB transceiver. That port can be wired through a UTMI+ switch to either an OTG controller or a host controller. Each UTMI+ lane is 8 bits wide. Software or a boot agent issues claim requests. A claim names a port index, an argument count and a one-bit selector. The block validates the claim and returns a one-cycle result pulse carrying a 2-bit code.

The first valid claim of the shared port fixes the switch. It drives the selector onto the switch-select output and records it. From then on, a claim that asks for the same routing is accepted. A claim that asks for the other routing is refused as busy, and the switch does not move. No release operation exists: only reset returns the switch to its open state.

A small read port exposes two words. The miscellaneous word carries the switch-select bit in bit 0. The version word carries the minor revision in bits [3:0] and the major revision in bits [7:4].

The switch state machine has two states, each with its own transitions:
- SW_OPEN is entered from reset. While open, a valid claim of port 1 causes transition TAKE into SW_LOCKED. Any other claim keeps SW_OPEN.
- SW_LOCKED has only the transition HOLD, back to itself, until reset.

Top module: `usbsw_claim_ctrl`

## Requirements
- R1: While reset is applied and after it is released, `resp_valid` is 0, `sw_locked` is 0 and `sw_host_sel` is 0.
- R2: Every request sampled on a rising edge produces exactly one `resp_valid` pulse on the following cycle, and no pulse occurs otherwise. The result codes are 00 OK, 01 invalid and 10 busy; code 11 never appears.
- R3: A claim of port 0 returns OK when its argument count is 0 and invalid for any other count.
- R4: A claim of port 1 whose argument count is not exactly 1 returns invalid, and it leaves `sw_locked` and `sw_host_sel` unchanged.
- R5: A claim naming a port index of 2 or more returns invalid.
- R6: While the switch is open, a claim of port 1 with one argument returns OK, copies its selector to `sw_host_sel` and sets `sw_locked`. Both are visible in the cycle of the response.
- R7: While locked, a port-1 claim with one argument whose selector differs from the recorded one returns busy and leaves `sw_host_sel` unchanged.
- R8: While locked, a port-1 claim with one argument whose selector equals the recorded one returns OK.
- R9: Once locked, the selection stays fixed until reset. Reset returns the block to the open state with `sw_host_sel` at 0.
- R10: A read is answered one cycle after `rd_en`, with `rd_valid` high for that cycle. Address 0x008 returns `sw_host_sel` in bit 0 and zeros elsewhere. Address 0x3F4 returns the major revision in bits [7:4] and the minor revision in bits [3:0]. Any other address returns 0.
- R11: Claims of port 0 and claims that return invalid never lock the switch.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Claim request strobe |
| req_port | input | PORT_W | Port index named by the claim |
| req_argc | input | ARGC_W | Argument count of the claim |
| req_sel | input | 1 | Selector argument (0 = OTG, 1 = host) |
| resp_valid | output | 1 | One-cycle result pulse |
| resp_code | output | 2 | Result: 00 OK, 01 invalid, 10 busy |
| sw_locked | output | 1 | Switch has been configured |
| sw_host_sel | output | 1 | Switch-select bit driven to the UTMI+ switch |
| rd_en | input | 1 | Register read strobe |
| rd_addr | input | ADDR_W | Register byte address |
| rd_valid | output | 1 | Read data valid |
| rd_data | output | DATA_W | Read data |

## Verification
A wrong lock state shows at the ports immediately. The next port-1 claim either returns OK where busy was due, or busy where OK was due. In the same cycle as that response, the switch-select output and the read-back of the miscellaneous word also disagree with the recorded selection. A lost or duplicated response is caught by the scoreboard. The scoreboard queue either runs empty when a pulse appears, or is still non-empty once traffic stops. Each claim sequence is followed by a switch-state comparison within one cycle of the response.

// File: rtl/usbsw_pkg.sv
package usbsw_pkg;

    typedef enum logic [1:0] {
        RES_OK      = 2'b00,
        RES_INVALID = 2'b01,
        RES_BUSY    = 2'b10
    } claim_res_e;

    typedef enum logic {
        SW_OPEN   = 1'b0,
        SW_LOCKED = 1'b1
    } sw_state_e;

endpackage

// File: rtl/usbsw_claim_decode.sv
module usbsw_claim_decode
    import usbsw_pkg::*;
#(
    parameter int PORT_W = 2,
    parameter int ARGC_W = 2
) (
    input  logic [PORT_W-1:0] port,
    input  logic [ARGC_W-1:0] argc,
    input  logic              sel,
    input  logic              locked,
    input  logic              rec_sel,
    output claim_res_e        res,
    output logic              take
);
    localparam logic [ARGC_W-1:0] ARGC_NONE = '0;
    localparam logic [ARGC_W-1:0] ARGC_ONE  = ARGC_W'(1);

    always_comb begin
        res  = RES_INVALID;
        take = 1'b0;
        if (port == PORT_W'(0)) begin
            res = (argc == ARGC_NONE) ? RES_OK : RES_INVALID;
        end else if (port == PORT_W'(1)) begin
            if (argc != ARGC_ONE) begin
                res = RES_INVALID;
            end else if (!locked) begin
                res  = RES_OK;
                take = 1'b1;
            end else begin
                res = (sel == rec_sel) ? RES_OK : RES_BUSY;
            end
        end
    end

endmodule

// File: rtl/usbsw_switch_fsm.sv
module usbsw_switch_fsm
    import usbsw_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic take,
    input  logic take_sel,
    output logic locked,
    output logic host_sel
);
    sw_state_e state_q, state_d;
    logic      sel_q, sel_d;

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= SW_OPEN;
            sel_q   <= 1'b0;
        end else begin
            state_q <= state_d;
            sel_q   <= sel_d;
        end
    end

    // transitions TAKE and HOLD
    always_comb begin
        state_d = state_q;
        sel_d   = sel_q;
        unique case (state_q)
            SW_OPEN: begin
                if (take) begin
                    state_d = SW_LOCKED;
                    sel_d   = take_sel;
                end
            end
            SW_LOCKED: begin
                state_d = SW_LOCKED;
            end
        endcase
    end

    // outputs
    always_comb begin
        locked   = (state_q == SW_LOCKED);
        host_sel = sel_q;
    end

endmodule

// File: rtl/usbsw_reg_read.sv
module usbsw_reg_read #(
    parameter int ADDR_W    = 12,
    parameter int DATA_W    = 32,
    parameter int MISC_OFS  = 'h008,
    parameter int VER_OFS   = 'h3F4,
    parameter int VER_MAJOR = 1,
    parameter int VER_MINOR = 0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] rd_addr,
    input  logic              host_sel,
    output logic              rd_valid,
    output logic [DATA_W-1:0] rd_data
);
    localparam logic [ADDR_W-1:0] MISC_A   = ADDR_W'(MISC_OFS);
    localparam logic [ADDR_W-1:0] VER_A    = ADDR_W'(VER_OFS);
    localparam logic [DATA_W-1:0] VER_WORD =
        DATA_W'(((VER_MAJOR % 16) * 16) + (VER_MINOR % 16));

    logic [DATA_W-1:0] word_d;

    always_comb begin
        word_d = '0;
        if (rd_addr == MISC_A) begin
            word_d[0] = host_sel;
        end else if (rd_addr == VER_A) begin
            word_d = VER_WORD;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_valid <= 1'b0;
            rd_data  <= '0;
        end else begin
            rd_valid <= rd_en;
            rd_data  <= rd_en ? word_d : '0;
        end
    end

endmodule

// File: rtl/usbsw_claim_ctrl.sv
module usbsw_claim_ctrl
    import usbsw_pkg::*;
#(
    parameter int PORT_W    = 2,
    parameter int ARGC_W    = 2,
    parameter int ADDR_W    = 12,
    parameter int DATA_W    = 32,
    parameter int VER_MAJOR = 1,
    parameter int VER_MINOR = 0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic [PORT_W-1:0] req_port,
    input  logic [ARGC_W-1:0] req_argc,
    input  logic              req_sel,
    output logic              resp_valid,
    output logic [1:0]        resp_code,
    output logic              sw_locked,
    output logic              sw_host_sel,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic              rd_valid,
    output logic [DATA_W-1:0] rd_data
);
    claim_res_e res;
    logic       take;

    usbsw_claim_decode #(.PORT_W(PORT_W), .ARGC_W(ARGC_W)) i_decode (
        .port    (req_port),
        .argc    (req_argc),
        .sel     (req_sel),
        .locked  (sw_locked),
        .rec_sel (sw_host_sel),
        .res     (res),
        .take    (take)
    );

    usbsw_switch_fsm i_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .take     (take && req_valid),
        .take_sel (req_sel),
        .locked   (sw_locked),
        .host_sel (sw_host_sel)
    );

    usbsw_reg_read #(
        .ADDR_W    (ADDR_W),
        .DATA_W    (DATA_W),
        .VER_MAJOR (VER_MAJOR),
        .VER_MINOR (VER_MINOR)
    ) i_rd (
        .clk      (clk),
        .rst_n    (rst_n),
        .rd_en    (rd_en),
        .rd_addr  (rd_addr),
        .host_sel (sw_host_sel),
        .rd_valid (rd_valid),
        .rd_data  (rd_data)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            resp_valid <= 1'b0;
            resp_code  <= RES_OK;
        end else begin
            resp_valid <= req_valid;
            resp_code  <= req_valid ? res : RES_OK;
        end
    end

endmodule

// File: rtl/usbsw_claim_sva.sv
module usbsw_claim_sva #(
    parameter int PORT_W = 2,
    parameter int ARGC_W = 2
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_valid,
    input logic [PORT_W-1:0] req_port,
    input logic [ARGC_W-1:0] req_argc,
    input logic              req_sel,
    input logic              resp_valid,
    input logic [1:0]        resp_code,
    input logic              sw_locked,
    input logic              sw_host_sel,
    input logic              rd_en,
    input logic              rd_valid
);
    assert_resp_follows_R2: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> resp_valid);
    assert_resp_quiet_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> !resp_valid);
    assert_code_legal_R2: assert property (@(posedge clk) disable iff (!rst_n)
        resp_valid |-> resp_code != 2'b11);
    assert_port0_ok_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_port == PORT_W'(0) && req_argc == ARGC_W'(0)) |=> resp_code == 2'b00);
    assert_port1_argc_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_port == PORT_W'(1) && req_argc != ARGC_W'(1))
        |=> (resp_code == 2'b01 && $stable(sw_locked) && $stable(sw_host_sel)));
    assert_bad_port_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_port > PORT_W'(1)) |=> resp_code == 2'b01);
    assert_lock_source_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sw_locked) |-> ($past(req_valid) && $past(req_port) == PORT_W'(1)
                              && sw_host_sel == $past(req_sel)));
    assert_busy_no_move_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (resp_valid && resp_code == 2'b10) |-> $stable(sw_host_sel));
    assert_lock_holds_R9: assert property (@(posedge clk) disable iff (!rst_n)
        sw_locked |=> (sw_locked && $stable(sw_host_sel)));
    assert_read_ack_R10: assert property (@(posedge clk) disable iff (!rst_n)
        rd_en |=> rd_valid);
endmodule

bind usbsw_claim_ctrl usbsw_claim_sva #(.PORT_W(PORT_W), .ARGC_W(ARGC_W)) i_sva (
    .clk         (clk),
    .rst_n       (rst_n),
    .req_valid   (req_valid),
    .req_port    (req_port),
    .req_argc    (req_argc),
    .req_sel     (req_sel),
    .resp_valid  (resp_valid),
    .resp_code   (resp_code),
    .sw_locked   (sw_locked),
    .sw_host_sel (sw_host_sel),
    .rd_en       (rd_en),
    .rd_valid    (rd_valid)
);

// File: tb/test_usbsw_claim_ctrl.sv
module test_usbsw_claim_ctrl;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic [1:0]  req_port = '0;
    logic [1:0]  req_argc = '0;
    logic        req_sel = 1'b0;
    logic        resp_valid;
    logic [1:0]  resp_code;
    logic        sw_locked;
    logic        sw_host_sel;
    logic        rd_en = 1'b0;
    logic [11:0] rd_addr = '0;
    logic        rd_valid;
    logic [31:0] rd_data;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    // bench model of the switch
    bit m_locked = 1'b0;
    bit m_sel = 1'b0;

    logic [1:0] exp_code_q[$];
    string      exp_tag_q[$];

    always #5 clk = ~clk;

    usbsw_claim_ctrl #(.VER_MAJOR(2), .VER_MINOR(5)) i_usbsw_claim_ctrl (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_port(req_port),
        .req_argc(req_argc), .req_sel(req_sel), .resp_valid(resp_valid),
        .resp_code(resp_code), .sw_locked(sw_locked), .sw_host_sel(sw_host_sel),
        .rd_en(rd_en), .rd_addr(rd_addr), .rd_valid(rd_valid), .rd_data(rd_data)
    );

    task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    // monitor: pops expected results as pulses appear
    always @(negedge clk) begin
        if (rst_n && resp_valid) begin
            if (exp_code_q.size() == 0) begin
                check("R2 unexpected pulse", 32'(resp_valid), 32'(0));
            end else begin
                check(exp_tag_q.pop_front(), 32'(resp_code), 32'(exp_code_q.pop_front()));
            end
        end
    end

    // driver: one claim per cycle, called at a negedge
    task automatic claim(int port, int argc, bit sel, string tag);
        logic [1:0] e;
        if (port > 1) e = 2'b01;
        else if (port == 0) e = (argc == 0) ? 2'b00 : 2'b01;
        else if (argc != 1) e = 2'b01;
        else if (!m_locked) begin
            e = 2'b00; m_locked = 1'b1; m_sel = sel;
        end else e = (sel == m_sel) ? 2'b00 : 2'b10;
        exp_code_q.push_back(e);
        exp_tag_q.push_back(tag);
        req_valid = 1'b1;
        req_port  = 2'(port);
        req_argc  = 2'(argc);
        req_sel   = sel;
        @(negedge clk);
        check({tag, " lock"}, 32'(sw_locked), 32'(m_locked));
        check({tag, " sel"}, 32'(sw_host_sel), 32'(m_sel));
    endtask

    task automatic idle();
        req_valid = 1'b0;
        @(negedge clk);
        check("R2 no pulse when idle", 32'(resp_valid), 32'(0));
    endtask

    task automatic rd(logic [11:0] a, logic [31:0] e, string tag);
        rd_en = 1'b1;
        rd_addr = a;
        @(negedge clk);
        rd_en = 1'b0;
        check({tag, " valid"}, 32'(rd_valid), 32'(1));
        check({tag, " data"}, rd_data, e);
        @(negedge clk);
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        req_valid = 1'b0;
        m_locked = 1'b0;
        m_sel = 1'b0;
        repeat (3) @(negedge clk);
        check("R1 resp_valid in reset", 32'(resp_valid), 32'(0));
        check("R9 R1 lock cleared", 32'(sw_locked), 32'(0));
        check("R9 R1 sel cleared", 32'(sw_host_sel), 32'(0));
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    initial begin
        do_reset();
        check("R1 resp_valid after reset", 32'(resp_valid), 32'(0));
        rd(12'h008, 32'h0, "R10 misc after reset");
        rd(12'h3F4, 32'h25, "R10 version");
        rd(12'h000, 32'h0, "R10 other address");
        rd(12'h00C, 32'h0, "R10 unmapped");

        claim(0, 0, 1'b0, "R3 port0 argc0"); idle();
        claim(0, 1, 1'b1, "R3 port0 argc1"); idle();
        claim(0, 3, 1'b0, "R3 R11 port0 argc3"); idle();
        claim(2, 0, 1'b1, "R5 port2"); idle();
        claim(3, 1, 1'b1, "R5 R11 port3 argc1"); idle();
        claim(1, 0, 1'b1, "R4 port1 argc0"); idle();
        claim(1, 2, 1'b1, "R4 port1 argc2"); idle();
        // back-to-back run: invalid, then first valid claim locks
        claim(1, 3, 1'b0, "R4 port1 argc3");
        claim(1, 1, 1'b1, "R6 first claim");
        claim(1, 1, 1'b0, "R7 busy differing");
        claim(1, 1, 1'b1, "R8 matching ok");
        idle();
        rd(12'h008, 32'h1, "R10 R6 misc after lock");
        claim(1, 0, 1'b0, "R4 port1 argc0 locked"); idle();
        claim(0, 0, 1'b0, "R3 port0 while locked"); idle();
        repeat (4) begin
            claim(1, 1, 1'b0, "R9 R7 still busy");
        end
        idle();

        do_reset();
        claim(1, 1, 1'b0, "R9 R6 relock sel0"); idle();
        rd(12'h008, 32'h0, "R10 misc sel0");
        claim(1, 1, 1'b1, "R7 busy sel1"); idle();
        claim(1, 1, 1'b0, "R8 match sel0"); idle();
        repeat (2) @(negedge clk);
        check("R2 all responses seen", 32'(exp_code_q.size()), 32'(0));
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual hung expected done");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end
endmodule